// File: doc/BRIEF.md
# Dual-Granularity Chip-Select Decoder

This block turns the 16-bit address of an 8-bit processor into active-low chip selects at two sizes at the same time. The coarse decoder splits the 64K space into eight 8K blocks using the three top address bits. The fine decoder covers only the top 256-byte page ($FF00-$FFFF) and splits it into eight 32-byte device slots using address bits 7 to 5. A page detector drives the two decoders: when the address falls in the top page, only the slot decoder may select. Everywhere else, only the block decoder may select.

Block 7 and slot 7 share one ROM select. That select covers the start-up ROM in $E000-$FEFF and the vector slot $FFE0-$FFFF. A second ROM uses the block at $2000, RAM uses the block at $0000, and a spare device uses the block at $C000. Slots 0 and 1 select two parallel ports, and slot 2 selects a spare I/O device. Decoding is partial: a small device in a larger region repeats across it. Every select needs the bus-valid strobe high. An active-low cartridge input turns off both decoders.

Top module: `dual_grain_addr_decoder`

## Requirements
- R1: When cart_dis_n_i is 0, all seven selects are 1 at every address.
- R2: When bus_valid_i is 0, all seven selects are 1 at every address.
- R3: With the decoder enabled (bus_valid_i=1, cart_dis_n_i=1), ram_cs_n_o is 0 exactly for addresses $0000-$1FFF.
- R4: With the decoder enabled, rom2_cs_n_o is 0 exactly for addresses $2000-$3FFF.
- R5: With the decoder enabled, aux_blk_cs_n_o is 0 exactly for addresses $C000-$DFFF.
- R6: With the decoder enabled, rom_cs_n_o is 0 exactly for addresses $E000-$FEFF and $FFE0-$FFFF.
- R7: With the decoder enabled, port0_cs_n_o is 0 exactly for $FF00-$FF1F, port1_cs_n_o exactly for $FF20-$FF3F, and aux_io_cs_n_o exactly for $FF40-$FF5F.
- R8: With the decoder enabled, the unused blocks $4000-$BFFF and the unused slots $FF60-$FFDF drive every select to 1.
- R9: At no time is more than one select at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Processor address bus |
| bus_valid_i | input | 1 | High while the address is valid |
| cart_dis_n_i | input | 1 | Active-low cartridge input; low turns off all selects |
| rom_cs_n_o | output | 1 | Start-up ROM and vector slot select |
| rom2_cs_n_o | output | 1 | Second ROM select, 8K block at $2000 |
| ram_cs_n_o | output | 1 | RAM select, 8K block at $0000 |
| aux_blk_cs_n_o | output | 1 | Spare 8K select, block at $C000 |
| port0_cs_n_o | output | 1 | Parallel port 0 select, slot $FF00 |
| port1_cs_n_o | output | 1 | Parallel port 1 select, slot $FF20 |
| aux_io_cs_n_o | output | 1 | Spare 32-byte select, slot $FF40 |

## Verification
The bound assertions check on every cycle that the cartridge input and the strobe force all selects high, that at most one select is low, that the RAM select appears only in the bottom block, and that the I/O slot selects appear only inside the top page. The exact edges of each region cannot be shown by these invariants. These include the hand-off at $FEFF/$FF00 between the ROM block and the port slot, the return of the ROM select at $FFE0, and the dead slots and blocks. Only the bench shows these, by sweeping every address against its behavioural map.

// File: rtl/dual_grain_addr_decoder.sv
module dual_grain_addr_decoder #(
  parameter int ADDR_W    = 16,
  parameter int BLK_BITS  = 3,
  parameter int SLOT_BITS = 3,
  parameter int SLOT_LSB  = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bus_valid_i,
  input  logic              cart_dis_n_i,
  output logic              rom_cs_n_o,
  output logic              rom2_cs_n_o,
  output logic              ram_cs_n_o,
  output logic              aux_blk_cs_n_o,
  output logic              port0_cs_n_o,
  output logic              port1_cs_n_o,
  output logic              aux_io_cs_n_o
);
  localparam int NBLK     = 1 << BLK_BITS;
  localparam int NSLOT    = 1 << SLOT_BITS;
  localparam int PAGE_LSB = SLOT_LSB + SLOT_BITS;

  logic             enable;
  logic             page_hit;
  logic [NBLK-1:0]  blk;
  logic [NSLOT-1:0] slot;

  assign enable   = bus_valid_i & cart_dis_n_i;
  assign page_hit = &addr_i[ADDR_W-1:PAGE_LSB];

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    assign blk[i] = enable & ~page_hit &
                    (addr_i[ADDR_W-1 -: BLK_BITS] == BLK_BITS'(i));
  end

  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    assign slot[j] = enable & page_hit &
                     (addr_i[PAGE_LSB-1 -: SLOT_BITS] == SLOT_BITS'(j));
  end

  assign rom_cs_n_o     = ~(blk[NBLK-1] | slot[NSLOT-1]);
  assign aux_blk_cs_n_o = ~blk[6];
  assign rom2_cs_n_o    = ~blk[1];
  assign ram_cs_n_o     = ~blk[0];
  assign port0_cs_n_o   = ~slot[0];
  assign port1_cs_n_o   = ~slot[1];
  assign aux_io_cs_n_o  = ~slot[2];

  logic unused_bits;
  assign unused_bits = ^{blk[5:2], slot[6:3], addr_i[SLOT_LSB-1:0]};
endmodule

// File: rtl/dual_grain_addr_decoder_chk.sv
module dual_grain_addr_decoder_chk (
  input logic [15:0] addr_i,
  input logic        bus_valid_i,
  input logic        cart_dis_n_i,
  input logic        rom_cs_n_o,
  input logic        rom2_cs_n_o,
  input logic        ram_cs_n_o,
  input logic        aux_blk_cs_n_o,
  input logic        port0_cs_n_o,
  input logic        port1_cs_n_o,
  input logic        aux_io_cs_n_o
);
  logic [6:0] sel_n;
  assign sel_n = {rom_cs_n_o, rom2_cs_n_o, ram_cs_n_o, aux_blk_cs_n_o,
                  port0_cs_n_o, port1_cs_n_o, aux_io_cs_n_o};

  always_comb begin
    if (!cart_dis_n_i)
      assert_cart_off_R1: assert (&sel_n) else $error("R1 select active while cartridge off");
    if (!bus_valid_i)
      assert_idle_bus_R2: assert (&sel_n) else $error("R2 select active without strobe");
    if (!ram_cs_n_o)
      assert_ram_block_R3: assert (addr_i[15:13] == 3'd0) else $error("R3 RAM outside block 0");
    if (!(port0_cs_n_o && port1_cs_n_o && aux_io_cs_n_o))
      assert_slot_page_R7: assert (addr_i[15:8] == 8'hFF) else $error("R7 slot select outside top page");
    assert_single_sel_R9: assert ($countones(~sel_n) <= 1) else $error("R9 several selects active");
  end
endmodule

bind dual_grain_addr_decoder dual_grain_addr_decoder_chk u_chk (
  .addr_i(addr_i), .bus_valid_i(bus_valid_i), .cart_dis_n_i(cart_dis_n_i),
  .rom_cs_n_o(rom_cs_n_o), .rom2_cs_n_o(rom2_cs_n_o), .ram_cs_n_o(ram_cs_n_o),
  .aux_blk_cs_n_o(aux_blk_cs_n_o), .port0_cs_n_o(port0_cs_n_o),
  .port1_cs_n_o(port1_cs_n_o), .aux_io_cs_n_o(aux_io_cs_n_o)
);

// File: tb/dual_grain_addr_decoder_tb.sv
`timescale 1ns/1ps
module dual_grain_addr_decoder_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] addr;
  logic        valid;
  logic        cart_n;
  logic        rom_n, rom2_n, ram_n, auxb_n, p0_n, p1_n, auxio_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  dual_grain_addr_decoder u_dut (
    .addr_i(addr), .bus_valid_i(valid), .cart_dis_n_i(cart_n),
    .rom_cs_n_o(rom_n), .rom2_cs_n_o(rom2_n), .ram_cs_n_o(ram_n),
    .aux_blk_cs_n_o(auxb_n), .port0_cs_n_o(p0_n), .port1_cs_n_o(p1_n),
    .aux_io_cs_n_o(auxio_n)
  );

  // order: rom, rom2, ram, aux_blk, port0, port1, aux_io
  function automatic logic [6:0] model(int a, bit v, bit c);
    logic [6:0] e = 7'h7F;
    if (!v || !c) return e;
    if (a < 'h2000)                         e[4] = 1'b0;
    else if (a < 'h4000)                    e[5] = 1'b0;
    else if (a >= 'hC000 && a < 'hE000)     e[3] = 1'b0;
    else if (a >= 'hE000 && a < 'hFF00)     e[6] = 1'b0;
    else if (a >= 'hFF00 && a < 'hFF20)     e[2] = 1'b0;
    else if (a >= 'hFF20 && a < 'hFF40)     e[1] = 1'b0;
    else if (a >= 'hFF40 && a < 'hFF60)     e[0] = 1'b0;
    else if (a >= 'hFFE0)                   e[6] = 1'b0;
    return e;
  endfunction

  function automatic string req_of(int a, bit v, bit c);
    if (!c) return "R1";
    if (!v) return "R2";
    if (a < 'h2000) return "R3";
    if (a < 'h4000) return "R4";
    if (a < 'hC000) return "R8";
    if (a < 'hE000) return "R5";
    if (a < 'hFF00 || a >= 'hFFE0) return "R6";
    if (a < 'hFF60) return "R7";
    return "R8";
  endfunction

  task automatic apply_and_check(int a, bit v, bit c);
    logic [6:0] got, exp;
    @(posedge clk);
    addr = 16'(a); valid = v; cart_n = c;
    @(negedge clk);
    got = {rom_n, rom2_n, ram_n, auxb_n, p0_n, p1_n, auxio_n};
    exp = model(a, v, c);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%04h got=%07b exp=%07b", req_of(a, v, c), a, got, exp);
    end
    checks++;
    if ($countones(~got) > 1) begin
      errors++;
      $display("FAIL R9 addr=%04h got=%07b exp=at most one zero", a, got);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog expired got=%0d cycles exp=fewer", cycles);
      finish_run();
    end
  end

  initial begin
    addr = 16'h0000; valid = 1'b0; cart_n = 1'b1;
    // idle state, strobe low (R2)
    apply_and_check('h0000, 1'b0, 1'b1);
    // boundary points named per requirement: R3 R4 R5 R6 R7 R8
    apply_and_check('h1FFF, 1'b1, 1'b1);
    apply_and_check('h2000, 1'b1, 1'b1);
    apply_and_check('hDFFF, 1'b1, 1'b1);
    apply_and_check('hFEFF, 1'b1, 1'b1);
    apply_and_check('hFF00, 1'b1, 1'b1);
    apply_and_check('hFF5F, 1'b1, 1'b1);
    apply_and_check('hFF60, 1'b1, 1'b1);
    apply_and_check('hFFDF, 1'b1, 1'b1);
    apply_and_check('hFFE0, 1'b1, 1'b1);
    // full sweep with the decoder enabled (R3..R9)
    for (int a = 0; a < 65536; a++) apply_and_check(a, 1'b1, 1'b1);
    // cartridge off across the map (R1), strides hit the top page too
    for (int a = 0; a < 65536; a += 13) apply_and_check(a, 1'b1, 1'b0);
    for (int a = 'hFF00; a < 65536; a++) apply_and_check(a, 1'b1, 1'b0);
    // strobe low across the map (R2)
    for (int a = 5; a < 65536; a += 17) apply_and_check(a, 1'b0, 1'b1);
    for (int a = 'hFF00; a < 65536; a++) apply_and_check(a, 1'b0, 1'b1);
    finish_run();
  end
endmodule